// File: doc/BRIEF.md
# External Memory Access Controller

This block connects an internal master to an asynchronous 16-bit external memory bus. The master presents a request with a byte address, write data, a byte-lane mask and an access length. The controller decodes the address into one of three active-low chip selects. It then runs the read or write strobe sequence for the requested number of clock cycles and returns an acknowledge. A read acknowledge carries the data captured at the end of the access. An address that falls outside every region is answered with an error and produces no bus activity.

The access length is chosen per request and can be 2 to 9 cycles. Writes of 4 or more cycles hold the write strobe away from both ends of the access. Shorter writes keep the strobe low from the second cycle to the end. The top address pin can be switched to carry byte-address bit 0 for a narrow device.

When only one device is fitted, the eight control pins can be handed over to general-purpose output bits. In that case only reads of the first region are served.

Top module: `xmem_ctrl`

## Requirements
- R1: During and after reset, every chip select, read strobe, write strobe and byte strobe is high, the data drive enable is low, the acknowledge is low and the request-ready output is high.
- R2: A request is accepted on a clock edge where both req_valid and req_ready are high. For an accepted request of length L, cycle 1 is the cycle after acceptance. Chip select k is driven low in cycles 1..L, where k is the byte address shifted right by REGION_LOG2. No other chip select is driven low.
- R3: A request whose region index is NUM_CS or higher drives no strobe. It is answered with ack and ack_err both high in cycle 1.
- R4: The req_len field holds the access length in cycles. Values 2 to 9 are used as given, values 0 and 1 act as 2, and values 10 to 15 act as 9. The acknowledge of a legal access is high in cycle L+1 only.
- R5: A read drives the read strobe low in cycles 1..L. It samples mem_din at the end of cycle L and presents that value on ack_rdata in cycle L+1, with ack_err low.
- R6: A write of length 4 or more drives the write strobe low in cycles 2..L-1 only.
- R7: A write of length 2 or 3 drives the write strobe low in cycles 2..L.
- R8: The data drive enable is high in cycles 1..L of a write, with mem_dout equal to the request's write data. It is low in every other cycle, including every read cycle.
- R9: Byte strobe j (bit 0 is the lower byte) is low in cycles 1..L when req_mask bit j is 1. Otherwise it stays high.
- R10: req_ready is low in cycles 1..L and high in cycle L+1. A request held waiting is therefore started no earlier than cycle L+2, and cycle L+1 has no chip select active.
- R11: During an access, mem_addr[ADDR_W-3:0] carries byte address bits ADDR_W-2..1. The top pin mem_addr[ADDR_W-2] carries byte address bit ADDR_W-1, or byte address bit 0 when cfg_narrow is high.
- R12: While cfg_port_mode is high, the pins follow port_bits one cycle later, in this order: bit 0 read strobe, bits 1..NUM_CS chip selects, then write strobe, then top address pin, then the byte strobes with the lower byte first. In this mode a write, or a read outside region 0, is answered as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_port_mode | input | 1 | Hand the control pins over to port_bits |
| cfg_narrow | input | 1 | Top address pin carries byte address bit 0 |
| port_bits | input | 3+NUM_CS+DATA_W/8 | General-purpose values for the released pins |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte lanes to strobe, bit 0 lower byte |
| req_len | input | 4 | Access length in cycles |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Request was not mapped |
| ack_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W-1 | Word address with shared top pin |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_be_n | output | DATA_W/8 | Active-low byte strobes |
| mem_oe | output | 1 | Data bus drive enable |
| mem_dout | output | DATA_W | Data to drive on the bus |
| mem_din | input | DATA_W | Data read from the bus |

## Verification
The bench builds the controller with a 16-bit byte address and REGION_LOG2 of 14. This gives four 16 KB regions, of which three are mapped, so the unmapped quarter used for the error answer lies within a short address. The 16-bit data path gives two byte strobes and eight releasable pins. With these values every chip select, both write-strobe shapes, both clamped lengths, narrow and port modes and back-to-back requests can be reached in a few hundred cycles. The data returned by the modelled memory is a function of the word address, so a read that samples in the wrong cycle or at the wrong address is seen.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int LEN_W    = 4;
  localparam int LEN_MIN  = 2;
  localparam int LEN_MAX  = 9;
  localparam int LONG_MIN = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUSY = 2'd1,
    PH_GAP  = 2'd2
  } phase_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    if (raw < LEN_W'(LEN_MIN)) return LEN_W'(LEN_MIN);
    if (raw > LEN_W'(LEN_MAX)) return LEN_W'(LEN_MAX);
    return raw;
  endfunction

  // Write strobe window for access cycle cyc (1-based) of an access of length len
  function automatic logic wr_window(input logic [LEN_W-1:0] cyc, input logic [LEN_W-1:0] len);
    if (cyc < LEN_W'(2)) return 1'b0;
    if (len >= LEN_W'(LONG_MIN)) return (cyc <= len - LEN_W'(1));
    return 1'b1;
  endfunction

endpackage

// File: rtl/xmem_region_dec.sv
module xmem_region_dec #(
  parameter int IDX_W  = 2,
  parameter int NUM_CS = 3
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              is_write,
  input  logic              port_mode,
  output logic [NUM_CS-1:0] sel,
  output logic              err
);

  logic hit;

  for (genvar c = 0; c < NUM_CS; c++) begin : g_sel
    assign sel[c] = (idx == IDX_W'(c));
  end

  assign hit = |sel;
  assign err = !hit || (port_mode && (is_write || !sel[0]));

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_err,
  output logic             req_ready,
  output logic             accept,
  output logic             busy_d,
  output logic [LEN_W-1:0] cyc_d,
  output logic [LEN_W-1:0] len_d,
  output logic             capture,
  output logic             ack,
  output logic             ack_err
);

  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] cyc_q, len_q;
  logic             last;

  assign req_ready = (phase_q != PH_BUSY);
  assign accept    = req_valid && req_ready;
  assign last      = (phase_q == PH_BUSY) && (cyc_q == len_q);
  assign capture   = last;
  assign busy_d    = (phase_d == PH_BUSY);

  always_comb begin
    phase_d = phase_q;
    cyc_d   = cyc_q;
    len_d   = len_q;
    case (phase_q)
      PH_BUSY: begin
        if (last) phase_d = PH_GAP;
        else      cyc_d   = cyc_q + LEN_W'(1);
      end
      default: begin
        phase_d = PH_IDLE;
        if (accept) begin
          if (req_err) begin
            phase_d = PH_GAP;
          end else begin
            phase_d = PH_BUSY;
            cyc_d   = LEN_W'(1);
            len_d   = clamp_len(req_len);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      len_q   <= LEN_W'(LEN_MIN);
      ack     <= 1'b0;
      ack_err <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cyc_q   <= cyc_d;
      len_q   <= len_d;
      ack     <= last || (accept && req_err);
      ack_err <= accept && req_err;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BUSY) |-> (len_q >= LEN_W'(LEN_MIN) && len_q <= LEN_W'(LEN_MAX)
                              && cyc_q >= LEN_W'(1) && cyc_q <= len_q)); // R4

  AST_ACK_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last |=> (ack && !ack_err)); // R5

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (accept && req_err) |=> (phase_q != PH_BUSY)); // R3

endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 3,
  parameter int LANES  = DATA_W / 8,
  parameter int PORT_W = 3 + NUM_CS + LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_mode,
  input  logic              narrow,
  input  logic [PORT_W-1:0] port_bits,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [NUM_CS-1:0] req_sel,
  input  logic              busy_d,
  input  logic [LEN_W-1:0]  cyc_d,
  input  logic [LEN_W-1:0]  len_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              mem_oe,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rdata
);

  localparam int RD_BIT = 0;
  localparam int CS_LSB = 1;
  localparam int WR_BIT = NUM_CS + 1;
  localparam int SH_BIT = NUM_CS + 2;
  localparam int BE_LSB = NUM_CS + 3;
  localparam int LO_W   = ADDR_W - 2;
  localparam logic [PORT_W-1:0] CTL_IDLE = ~(PORT_W'(1) << SH_BIT);

  logic              wr_h, sh_h;
  logic [LANES-1:0]  mask_h;
  logic [NUM_CS-1:0] sel_h;
  logic              wr_s, sh_s, sh_new;
  logic [LANES-1:0]  mask_s;
  logic [NUM_CS-1:0] sel_s;
  logic              strobe_ok;
  logic [PORT_W-1:0] ctl_raw, ctl_q;
  logic [LO_W-1:0]   addr_lo_q;
  logic              pmode_q;

  assign sh_new    = narrow ? req_addr[0] : req_addr[ADDR_W-1];
  assign wr_s      = accept ? req_write : wr_h;
  assign sh_s      = accept ? sh_new    : sh_h;
  assign mask_s    = accept ? req_mask  : mask_h;
  assign sel_s     = accept ? req_sel   : sel_h;
  assign strobe_ok = wr_window(cyc_d, len_d);

  assign ctl_raw[RD_BIT] = ~(busy_d & ~wr_s);
  assign ctl_raw[WR_BIT] = ~(busy_d & wr_s & strobe_ok);
  assign ctl_raw[SH_BIT] = sh_s;

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign ctl_raw[CS_LSB+c] = ~(busy_d & sel_s[c]);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign ctl_raw[BE_LSB+j] = ~(busy_d & mask_s[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_h      <= 1'b0;
      sh_h      <= 1'b0;
      mask_h    <= '0;
      sel_h     <= '0;
      ctl_q     <= CTL_IDLE;
      mem_oe    <= 1'b0;
      mem_dout  <= '0;
      addr_lo_q <= '0;
      rdata     <= '0;
      pmode_q   <= 1'b0;
    end else begin
      wr_h    <= wr_s;
      sh_h    <= sh_s;
      mask_h  <= mask_s;
      sel_h   <= sel_s;
      ctl_q   <= port_mode ? port_bits : ctl_raw;
      mem_oe  <= busy_d & wr_s;
      pmode_q <= port_mode;
      if (accept) begin
        addr_lo_q <= req_addr[ADDR_W-2:1];
        if (req_write) mem_dout <= req_wdata;
      end
      if (capture) rdata <= mem_din;
    end
  end

  assign mem_rd_n = ctl_q[RD_BIT];
  assign mem_wr_n = ctl_q[WR_BIT];
  assign mem_cs_n = ctl_q[CS_LSB +: NUM_CS];
  assign mem_be_n = ctl_q[BE_LSB +: LANES];
  assign mem_addr = {ctl_q[SH_BIT], addr_lo_q};

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    !pmode_q |-> $onehot0(~mem_cs_n)); // R2

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!pmode_q && mem_oe) |-> mem_rd_n); // R8

  AST_WR_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!pmode_q && !mem_wr_n) |-> (!(&mem_cs_n) && mem_oe)); // R6

  AST_RD_TURN: assert property (@(posedge clk) disable iff (rst)
    (!pmode_q && !$past(pmode_q) && $rose(mem_rd_n)) |-> (&mem_cs_n)); // R10

  AST_WR_TURN: assert property (@(posedge clk) disable iff (rst)
    (!pmode_q && !$past(pmode_q) && $fell(mem_oe)) |-> (mem_rd_n && (&mem_cs_n))); // R10

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int NUM_CS      = 3,
  parameter int REGION_LOG2 = 21,
  localparam int LANES      = DATA_W / 8,
  localparam int PORT_W     = 3 + NUM_CS + LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_port_mode,
  input  logic              cfg_narrow,
  input  logic [PORT_W-1:0] port_bits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [LEN_W-1:0]  req_len,
  output logic              ack,
  output logic              ack_err,
  output logic [DATA_W-1:0] ack_rdata,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              mem_oe,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int IDX_W = ADDR_W - REGION_LOG2;

  logic [NUM_CS-1:0] sel;
  logic              dec_err;
  logic              accept, busy_d, capture;
  logic [LEN_W-1:0]  cyc_d, len_d;

  xmem_region_dec #(.IDX_W(IDX_W), .NUM_CS(NUM_CS)) u_dec (
    .idx       (req_addr[ADDR_W-1:REGION_LOG2]),
    .is_write  (req_write),
    .port_mode (cfg_port_mode),
    .sel       (sel),
    .err       (dec_err)
  );

  xmem_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_err   (dec_err),
    .req_ready (req_ready),
    .accept    (accept),
    .busy_d    (busy_d),
    .cyc_d     (cyc_d),
    .len_d     (len_d),
    .capture   (capture),
    .ack       (ack),
    .ack_err   (ack_err)
  );

  xmem_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CS (NUM_CS),
    .LANES  (LANES),
    .PORT_W (PORT_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .port_mode (cfg_port_mode),
    .narrow    (cfg_narrow),
    .port_bits (port_bits),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .req_sel   (sel),
    .busy_d    (busy_d),
    .cyc_d     (cyc_d),
    .len_d     (len_d),
    .capture   (capture),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_be_n  (mem_be_n),
    .mem_oe    (mem_oe),
    .mem_dout  (mem_dout),
    .rdata     (ack_rdata)
  );

  AST_ERR_ACK_PAIR: assert property (@(posedge clk) disable iff (rst)
    ack_err |-> ack); // R3

endmodule

// File: tb/sim_xmem_ctrl.sv
module sim_xmem_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_port_mode = 1'b0, cfg_narrow = 1'b0;
  logic [7:0]  port_bits = 8'h00;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = 2'b11;
  logic [3:0]  req_len = 4'd2;
  logic        req_ready, ack, ack_err;
  logic [15:0] ack_rdata, mem_dout, mem_din;
  logic [14:0] mem_addr;
  logic [2:0]  mem_cs_n;
  logic        mem_rd_n, mem_wr_n, mem_oe;
  logic [1:0]  mem_be_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xmem_ctrl #(.ADDR_W(16), .DATA_W(16), .NUM_CS(3), .REGION_LOG2(14)) u0 (
    .clk(clk), .rst(rst), .cfg_port_mode(cfg_port_mode), .cfg_narrow(cfg_narrow),
    .port_bits(port_bits), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .req_len(req_len), .ack(ack), .ack_err(ack_err),
    .ack_rdata(ack_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_be_n(mem_be_n),
    .mem_oe(mem_oe), .mem_dout(mem_dout), .mem_din(mem_din)
  );

  // memory model: data is a function of the word address pins
  assign mem_din = {mem_addr[7:0], ~mem_addr[13:6]};

  typedef struct packed {
    logic        busy;
    logic        ack;
    logic        err;
    logic        chk_rd;
    logic [2:0]  cs_n;
    logic        rd_n;
    logic        wr_n;
    logic [1:0]  be_n;
    logic        oe;
    logic [13:0] alo;
    logic        sh;
    logic [15:0] dout;
    logic [15:0] rdat;
  } exp_t;

  exp_t q[$];
  logic       rst_prev = 1'b1;
  logic       mode_prev = 1'b0;
  logic [7:0] port_prev = 8'h00;

  function automatic exp_t idle_e();
    exp_t e;
    e = '0;
    e.cs_n = 3'b111;
    e.rd_n = 1'b1;
    e.wr_n = 1'b1;
    e.be_n = 2'b11;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_access();
    int idx, len;
    bit err;
    exp_t e;
    logic [13:0] wa;
    idx = int'(req_addr[15:14]);
    err = (idx >= 3) || (cfg_port_mode && (req_write || idx != 0));
    if (err) begin
      e = idle_e();
      e.ack = 1'b1;
      e.err = 1'b1;
      q.push_back(e);
      return;
    end
    len = int'(req_len);
    if (len < 2) len = 2;
    if (len > 9) len = 9;
    wa = req_addr[14:1];
    for (int k = 1; k <= len; k++) begin
      e = idle_e();
      e.busy = 1'b1;
      e.cs_n = ~(3'b001 << idx);
      e.rd_n = req_write;
      if (req_write) begin
        if (len >= 4) e.wr_n = !(k >= 2 && k <= len - 1);
        else          e.wr_n = !(k >= 2);
      end
      e.be_n = ~req_mask;
      e.oe   = req_write;
      e.alo  = wa;
      e.sh   = cfg_narrow ? req_addr[0] : req_addr[15];
      e.dout = req_wdata;
      q.push_back(e);
    end
    e = idle_e();
    e.ack    = 1'b1;
    e.chk_rd = !req_write;
    e.rdat   = {wa[7:0], ~wa[13:6]};
    q.push_back(e);
  endtask

  // cycle-by-cycle comparison against the queued expectation
  always @(negedge clk) begin
    exp_t e;
    if (!rst_prev && !done) begin
      e = (q.size() > 0) ? q.pop_front() : idle_e();
      if (mode_prev) begin
        check({mem_be_n, mem_addr[14], mem_wr_n, mem_cs_n, mem_rd_n} == port_prev, "R12 released pins",
              32'({mem_be_n, mem_addr[14], mem_wr_n, mem_cs_n, mem_rd_n}), 32'(port_prev));
      end else begin
        check(mem_cs_n == e.cs_n, "R2 chip selects", 32'(mem_cs_n), 32'(e.cs_n));
        check(mem_rd_n == e.rd_n, "R5 read strobe", 32'(mem_rd_n), 32'(e.rd_n));
        check(mem_wr_n == e.wr_n, "R6 R7 write strobe", 32'(mem_wr_n), 32'(e.wr_n));
        check(mem_be_n == e.be_n, "R9 byte strobes", 32'(mem_be_n), 32'(e.be_n));
        if (e.busy)
          check(mem_addr == {e.sh, e.alo}, "R11 address pins", 32'(mem_addr), 32'({e.sh, e.alo}));
      end
      check(mem_oe == e.oe, "R8 drive enable", 32'(mem_oe), 32'(e.oe));
      if (e.oe) check(mem_dout == e.dout, "R8 write data", 32'(mem_dout), 32'(e.dout));
      check(req_ready == !e.busy, "R10 ready", 32'(req_ready), 32'(!e.busy));
      check({ack, ack_err} == {e.ack, e.err}, "R3 R4 ack/err", 32'({ack, ack_err}), 32'({e.ack, e.err}));
      if (e.chk_rd) check(ack_rdata == e.rdat, "R5 read data", 32'(ack_rdata), 32'(e.rdat));
    end
    #2;
    if (!rst && req_valid && req_ready) push_access();
    rst_prev  = rst;
    port_prev = port_bits;
    mode_prev = cfg_port_mode;
  end

  task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [3:0] l);
    @(negedge clk);
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    req_len   = l;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic release_bus();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic one(input bit w, input logic [15:0] a, input logic [15:0] d,
                     input logic [1:0] m, input logic [3:0] l);
    issue(w, a, d, m, l);
    release_bus();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R1: idle pins after reset
    check(mem_cs_n == 3'b111 && mem_rd_n && mem_wr_n && mem_be_n == 2'b11,
          "R1 idle strobes", 32'({mem_cs_n, mem_rd_n, mem_wr_n, mem_be_n}), 32'h7f);
    check(!mem_oe && !ack && req_ready, "R1 idle control", 32'({mem_oe, ack, req_ready}), 32'h1);

    // reads in each region (R2, R5, R9)
    one(1'b0, 16'h0124, 16'h0, 2'b11, 4'd2);
    one(1'b0, 16'h4ABC, 16'h0, 2'b01, 4'd5);
    one(1'b0, 16'hB7F2, 16'h0, 2'b10, 4'd9);
    // writes: short and long strobe shapes (R6, R7, R8)
    one(1'b1, 16'h8010, 16'hBEEF, 2'b10, 4'd3);
    one(1'b1, 16'h0222, 16'h1234, 2'b11, 4'd2);
    one(1'b1, 16'h4444, 16'hA5A5, 2'b01, 4'd4);
    one(1'b1, 16'h3FFE, 16'h0F0F, 2'b11, 4'd9);
    // clamped lengths (R4)
    one(1'b1, 16'h1000, 16'h7777, 2'b11, 4'd0);
    one(1'b0, 16'h5002, 16'h0, 2'b11, 4'd1);
    one(1'b0, 16'h9006, 16'h0, 2'b11, 4'd15);
    one(1'b1, 16'h600A, 16'hC3C3, 2'b11, 4'd12);
    // unmapped region (R3)
    one(1'b0, 16'hC000, 16'h0, 2'b11, 4'd4);
    one(1'b1, 16'hFFFE, 16'h9999, 2'b11, 4'd6);
    // back-to-back, request held ready (R10)
    issue(1'b1, 16'h0100, 16'h1111, 2'b11, 4'd4);
    issue(1'b0, 16'h4102, 16'h0, 2'b11, 4'd2);
    issue(1'b0, 16'hC100, 16'h0, 2'b11, 4'd2);
    issue(1'b1, 16'h8104, 16'h2222, 2'b01, 4'd3);
    release_bus();
    repeat (12) @(negedge clk);
    // narrow device on the shared top pin (R11)
    @(negedge clk);
    cfg_narrow = 1'b1;
    one(1'b0, 16'h8003, 16'h0, 2'b11, 4'd3);
    one(1'b1, 16'h0005, 16'h5A5A, 2'b01, 4'd5);
    @(negedge clk);
    cfg_narrow = 1'b0;
    // released control pins (R12)
    @(negedge clk);
    cfg_port_mode = 1'b1;
    port_bits = 8'hA5;
    repeat (3) @(negedge clk);
    issue(1'b0, 16'h0040, 16'h0, 2'b11, 4'd4);
    @(negedge clk);
    req_valid = 1'b0;
    port_bits = 8'h3C;
    repeat (3) @(negedge clk);
    port_bits = 8'h81;
    repeat (8) @(negedge clk);
    one(1'b0, 16'h4040, 16'h0, 2'b11, 4'd3);
    one(1'b1, 16'h0042, 16'h4321, 2'b11, 4'd3);
    @(negedge clk);
    cfg_port_mode = 1'b0;
    repeat (4) @(negedge clk);
    one(1'b0, 16'h0046, 16'h0, 2'b11, 4'd2);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule